// File: doc/BRIEF.md
# Path-History Indirect Target Predictor

This block refines the target prediction for indirect jumps whose destination changes with the path that led to them. It holds a direct-mapped, tagged table of targets. The table is looked up with a hash that mixes the global path history with the fetch address. The fetch stage presents the fetch address, the current global history and the target buffer's answer (hit, branch kind, target). In the same cycle the block returns the final predicted target and a flag that says which structure supplied it. The table's target replaces the target buffer's target only for branches that the target buffer classifies as indirect, and only when the table holds a matching entry.

The table starts empty. An indirect branch is tracked only by the target buffer until one of its instances resolves with a wrong target. The execute stage then reports that instance on the resolve port, with the address, the history seen at fetch and the real destination. The block writes the entry selected by that address and history. The history is part of the key, so one branch collects one entry for each distinct path that has mispredicted. Both ports are plain per-cycle strobes with no back-pressure. The block accepts a resolve report in every cycle, and the lookup answer is combinational from the current table contents.

Top module: `indirect_target_pred`

## Requirements
- R1: The key is formed from the exclusive-OR of fetch address bits [17:2] with the 12-bit history, zero-extended to 16 bits. Bits [7:0] of the result select the entry and bits [15:8] are its tag. Two address/history pairs that give the same 16-bit value therefore share an entry.
- R2: The table supplies the target, and `pred_from_table` is 1, only when all of these hold: `btb_hit` is 1, `btb_kind` is 2'b10 (indirect), and the selected entry is valid with a matching tag. `pred_target` is then the stored target.
- R3: In every other case `pred_target` equals `btb_target` and `pred_from_table` is 0. This covers the other kinds: 2'b00 conditional, 2'b01 direct, 2'b11 return.
- R4: Reset (active-low, asynchronous) invalidates every entry, so no lookup during or right after reset is served by the table.
- R5: A resolve report with `rs_valid`, `rs_indirect` and `rs_mispredict` all 1 writes valid, tag and `rs_target` into the entry selected by `rs_addr` and `rs_hist`. A lookup with the same key sees the new target from the next cycle on.
- R6: A resolve report with `rs_mispredict` at 0 changes no entry.
- R7: A resolve report with `rs_indirect` at 0 changes no entry, even when it mispredicted.
- R8: A mispredict on a key whose entry already hit overwrites that entry's target with the resolved target.
- R9: The same branch address resolved under different histories occupies separate entries and keeps a separate target for each history.
- R10: A key that maps to an occupied entry with a different tag misses. Writing that key evicts the former occupant, whose key then misses.
- R11: A lookup in the same cycle as a write to its entry sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | 32 | Fetch address of the looked-up branch |
| lk_hist | input | 12 | Global history at fetch |
| btb_hit | input | 1 | Target buffer hit for the fetch address |
| btb_kind | input | 2 | Branch kind from the target buffer (00 cond, 01 direct, 10 indirect, 11 return) |
| btb_target | input | 32 | Target from the target buffer |
| rs_valid | input | 1 | Resolve report present this cycle |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_hist | input | 12 | History the resolved branch saw at fetch |
| rs_indirect | input | 1 | Resolved branch is indirect |
| rs_mispredict | input | 1 | Resolved target differed from the prediction |
| rs_target | input | 32 | Actual resolved target |
| pred_target | output | 32 | Final predicted target |
| pred_from_table | output | 1 | 1 when the history table supplied `pred_target` |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 12-bit history, 256 entries and an 8-bit tag. With a 12-bit history, history bit 8 moves only the tag and leaves the index alone. Flipping that bit reaches same-index, different-tag conflicts directly, and changing the address and history together reaches shared keys. The random phase draws from four addresses and sixteen histories, which keeps hits, overwrites and evictions frequent across the 256 entries.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    BK_COND     = 2'b00,
    BK_DIRECT   = 2'b01,
    BK_INDIRECT = 2'b10,
    BK_RETURN   = 2'b11
  } br_kind_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 8,
  parameter int TAG_W    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int HASH_W = IDX_W + TAG_W;

  logic [HASH_W-1:0] addr_slice;
  logic [HASH_W-1:0] hist_fit;
  logic [HASH_W-1:0] mix;
  logic              unused_addr;

  assign addr_slice  = addr[ADDR_LSB +: HASH_W];
  assign unused_addr = ^addr;

  // history narrower than the key is zero-padded, wider is cut
  if (HIST_W >= HASH_W) begin : g_cut
    logic unused_hist;
    assign unused_hist = ^hist;
    assign hist_fit    = hist[HASH_W-1:0];
  end else begin : g_pad
    assign hist_fit = {{(HASH_W-HIST_W){1'b0}}, hist};
  end

  assign mix = addr_slice ^ hist_fit;
  assign idx = mix[IDX_W-1:0];
  assign tag = mix[HASH_W-1:IDX_W];
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_target,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_target
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] tgt_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
endmodule

// File: rtl/ipt_select.sv
module ipt_select import ipt_pkg::*; #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              btb_hit,
  input  logic [1:0]        btb_kind,
  input  logic [DATA_W-1:0] btb_target,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [TAG_W-1:0]  key_tag,
  input  logic [DATA_W-1:0] ent_target,
  output logic [DATA_W-1:0] sel_target,
  output logic              sel_table
);
  logic is_indirect;
  logic tbl_hit;

  always_comb begin
    is_indirect = btb_hit && (br_kind_e'(btb_kind) == BK_INDIRECT);
    tbl_hit     = ent_valid && (ent_tag == key_tag);
    sel_table   = is_indirect && tbl_hit;
    sel_target  = sel_table ? ent_target : btb_target;
  end
endmodule

// File: rtl/indirect_target_pred.sv
module indirect_target_pred #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 8,
  parameter int TAG_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic              btb_hit,
  input  logic [1:0]        btb_kind,
  input  logic [ADDR_W-1:0] btb_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic [HIST_W-1:0] rs_hist,
  input  logic              rs_indirect,
  input  logic              rs_mispredict,
  input  logic [ADDR_W-1:0] rs_target,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_from_table
);
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  rs_idx;
  logic [TAG_W-1:0]  rs_tag;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_target;
  logic              write_en;

  ipt_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .ADDR_LSB(ADDR_LSB),
             .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_hash (
    .addr(lk_addr), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag));

  ipt_hash #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .ADDR_LSB(ADDR_LSB),
             .IDX_W(IDX_W), .TAG_W(TAG_W)) u_rs_hash (
    .addr(rs_addr), .hist(rs_hist), .idx(rs_idx), .tag(rs_tag));

  // allocate on a wrong indirect target, overwrite when the entry existed
  assign write_en = rs_valid && rs_indirect && rs_mispredict;

  ipt_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_target(ent_target),
    .wr_en(write_en), .wr_idx(rs_idx), .wr_tag(rs_tag), .wr_target(rs_target));

  ipt_select #(.TAG_W(TAG_W), .DATA_W(ADDR_W)) u_select (
    .btb_hit(btb_hit), .btb_kind(btb_kind), .btb_target(btb_target),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .key_tag(lk_tag),
    .ent_target(ent_target), .sel_target(pred_target), .sel_table(pred_from_table));
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 8,
  parameter int TAG_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_addr,
  input logic [HIST_W-1:0] lk_hist,
  input logic              btb_hit,
  input logic [1:0]        btb_kind,
  input logic [ADDR_W-1:0] btb_target,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_addr,
  input logic [HIST_W-1:0] rs_hist,
  input logic              rs_indirect,
  input logic              rs_mispredict,
  input logic [ADDR_W-1:0] rs_target,
  input logic [ADDR_W-1:0] pred_target,
  input logic              pred_from_table
);
  AST_TABLE_ONLY_FOR_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_from_table |-> (btb_hit && btb_kind == 2'b10)); // R2

  AST_FALLBACK_IS_BTB: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_from_table |-> (pred_target == btb_target)); // R3

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !pred_from_table); // R4

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_indirect && rs_mispredict) |=>
      (!(lk_addr == $past(rs_addr) && lk_hist == $past(rs_hist) &&
         btb_hit && btb_kind == 2'b10) ||
       (pred_from_table && pred_target == $past(rs_target)))); // R5
endmodule

bind indirect_target_pred ipt_checker #(
  .ADDR_W(ADDR_W), .HIST_W(HIST_W), .ADDR_LSB(ADDR_LSB),
  .IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/indirect_target_pred_test.sv
`timescale 1ns/1ps
module indirect_target_pred_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [11:0] lk_hist = '0;
  logic        btb_hit = 1'b0;
  logic [1:0]  btb_kind = 2'b00;
  logic [31:0] btb_target = '0;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_addr = '0;
  logic [11:0] rs_hist = '0;
  logic        rs_indirect = 1'b0;
  logic        rs_mispredict = 1'b0;
  logic [31:0] rs_target = '0;
  logic [31:0] pred_target;
  logic        pred_from_table;

  int vectors = 0;
  int fails   = 0;

  logic [255:0] m_v;
  logic [7:0]   m_tag [256];
  logic [31:0]  m_tgt [256];

  always #2 clk = ~clk;

  indirect_target_pred uut (.*);

  function automatic logic [15:0] f_key(logic [31:0] a, logic [11:0] h);
    return a[17:2] ^ {4'h0, h};
  endfunction

  task automatic apply(input string req);
    logic [15:0] k;
    logic        es;
    logic [31:0] et;
    string       r;
    #1;
    k  = f_key(lk_addr, lk_hist);
    es = rst_n && btb_hit && btb_kind == 2'b10 && m_v[k[7:0]] && m_tag[k[7:0]] == k[15:8];
    et = es ? m_tgt[k[7:0]] : btb_target;
    r  = (req == "") ? (es ? "R2" : "R3") : req;
    vectors++;
    if (pred_target !== et || pred_from_table !== es) begin
      fails++;
      $display("FAIL %s: got target=%h src=%b, expected target=%h src=%b",
               r, pred_target, pred_from_table, et, es);
    end
    if (!rst_n) m_v = '0;
    else if (rs_valid && rs_indirect && rs_mispredict) begin
      k = f_key(rs_addr, rs_hist);
      m_v[k[7:0]]   = 1'b1;
      m_tag[k[7:0]] = k[15:8];
      m_tgt[k[7:0]] = rs_target;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] a, input logic [11:0] h,
                      input logic [1:0] kind, input logic hit);
    lk_addr = a; lk_hist = h; btb_kind = kind; btb_hit = hit;
    btb_target = a ^ 32'h5A5A_0000;
  endtask

  task automatic res(input logic v, input logic [31:0] a, input logic [11:0] h,
                     input logic ind, input logic mis, input logic [31:0] t);
    rs_valid = v; rs_addr = a; rs_hist = h; rs_indirect = ind;
    rs_mispredict = mis; rs_target = t;
  endtask

  localparam logic [31:0] A  = 32'h0000_4A10;
  localparam logic [11:0] H1 = 12'h035;
  localparam logic [11:0] H2 = 12'h135;  // same index as H1, other tag
  localparam logic [11:0] H3 = 12'h0C2;

  function automatic logic [31:0] pool_addr(int n);
    case (n)
      0: return 32'h0000_4A10;
      1: return 32'h0001_2F84;
      2: return 32'h0000_4E10;
      default: return 32'h0003_0008;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h00C0FFEE));
    m_v = '0;
    @(negedge clk);
    // R4: during reset
    look(A, H1, 2'b10, 1'b1);
    res(1'b1, A, H1, 1'b1, 1'b1, 32'hDEAD_0000);
    apply("R4");
    apply("R4");
    rst_n = 1'b1;
    res(1'b0, A, H1, 1'b1, 1'b1, 32'h0);
    apply("R4");
    // R6: correct prediction does not allocate
    res(1'b1, A, H1, 1'b1, 1'b0, 32'h1111_0000);
    apply("R6");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    apply("R6");
    // R7: non-indirect mispredict does not allocate
    res(1'b1, A, H1, 1'b0, 1'b1, 32'h2222_0000);
    apply("R7");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    apply("R7");
    // R11 then R5
    res(1'b1, A, H1, 1'b1, 1'b1, 32'h0000_7700);
    apply("R11");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    apply("R5");
    if (pred_from_table !== 1'b1) begin
      fails++; $display("FAIL R5: src=%b expected 1", pred_from_table);
    end
    vectors++;
    // R3: other kinds and btb miss fall back
    look(A, H1, 2'b11, 1'b1); apply("R3");
    look(A, H1, 2'b00, 1'b1); apply("R3");
    look(A, H1, 2'b10, 1'b0); apply("R3");
    // R9: second history for same branch
    res(1'b1, A, H3, 1'b1, 1'b1, 32'h0000_8800);
    look(A, H1, 2'b10, 1'b1); apply("R9");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    look(A, H3, 2'b10, 1'b1); apply("R9");
    look(A, H1, 2'b10, 1'b1); apply("R9");
    // R8: overwrite existing entry
    res(1'b1, A, H1, 1'b1, 1'b1, 32'h0000_9900);
    apply("R8");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    apply("R8");
    // R1: different address/history with the same key shares the entry
    look(A ^ (32'h0A5 << 2), H1 ^ 12'h0A5, 2'b10, 1'b1); apply("R1");
    // R10: same index, other tag misses, then evicts
    look(A, H2, 2'b10, 1'b1); apply("R10");
    res(1'b1, A, H2, 1'b1, 1'b1, 32'h0000_AA00);
    apply("R10");
    res(1'b0, A, H1, 1'b0, 1'b0, 32'h0);
    apply("R10");
    look(A, H1, 2'b10, 1'b1); apply("R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      look(pool_addr($urandom % 4), 12'(($urandom % 8) | (($urandom % 2) << 8)),
           2'($urandom % 4), ($urandom % 8) != 0);
      if ($urandom % 2) btb_kind = 2'b10;
      res(($urandom % 3) == 0, pool_addr($urandom % 4),
          12'(($urandom % 8) | (($urandom % 2) << 8)),
          ($urandom % 4) != 0, ($urandom % 2) == 0, $urandom);
      apply("");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule